// File: doc/BRIEF.md
# Adaptive Body Bias Code Controller

This block closes a digital loop around a replica of a die's critical path. Each clock, a timing-check input reports whether a transition launched into the replica arrived at its capture point within the externally applied target clock period. The controller samples that result through two flip-flops, so the analog bias has settled before a verdict is taken. It then steps a body-bias code, one unit per failing verdict, until the replica meets timing. The code drives an external digital-to-analog converter that sets the body voltage. With the default direction, a rising code means more forward bias on the pMOS devices, which makes the path faster.

When a verdict passes, the controller locks and holds the code until a restart pulse or a reset re-arms it. A direction input selects whether failing verdicts raise or lower the code. The code saturates at a configurable guard band. If a limit is reached before timing passes, stepping stops and a fault flag is raised. Once a good code is known, an override input can place an externally chosen code on the output without disturbing the loop's own state.

Top module: `abb_code_ctrl`

## Requirements
- R1: While reset is low and in the cycle after it is released, bias_code equals START_CODE (default 32), locked is 0 and limit_err is 0.
- R2: Verdicts are taken at a fixed pace. After a step, the next code change happens exactly WAIT_CYCLES+1 clocks later (default 5). A verdict uses the path result that passed through both detector flops.
- R3: Each failing verdict changes the code by exactly one. With dir_up=1 the code increments, and with dir_up=0 it decrements.
- R4: A passing verdict sets locked and freezes the code. After that, path_ok has no effect on bias_code or locked until a restart or reset. If the path already passes at START_CODE, the loop locks without taking a step.
- R5: The code never leaves [CODE_MIN, CODE_MAX] (default 4 to 60). A failing verdict at the limit in the current direction sets limit_err and stops stepping, with locked kept at 0. locked and limit_err are never 1 together.
- R6: A one-cycle restart pulse clears locked and limit_err on the next clock and keeps the current code. The loop then resumes stepping in the direction dir_up gives.
- R7: While ovr_sel=1, bias_code equals ovr_code in the same cycle. When ovr_sel returns to 0, bias_code shows the loop code again, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| path_ok | input | 1 | Replica path met the target period this cycle |
| dir_up | input | 1 | Step direction: 1 increments the code, 0 decrements it |
| restart | input | 1 | Re-arms the loop from its current code |
| ovr_sel | input | 1 | Selects the external code for the output |
| ovr_code | input | CODE_W | External bias code |
| bias_code | output | CODE_W | Code sent to the bias converter |
| locked | output | 1 | Timing met and code held |
| limit_err | output | 1 | Limit reached without meeting timing |

## Verification
The hardest situation to reach is a loop that is stuck at a guard-band limit and must then be re-armed in the other direction. The bench sets up a replica model whose required code lies outside the guard band, so the loop walks all the way to the limit and faults. It then reverses dir_up, moves the target inside the band and pulses restart. This shows that the fault clears, the code is kept, and the loop locks on the new target. The held-lock case is reached by forcing the model to fail after lock and watching that the outputs stay put.

// File: rtl/abb_pkg.sv
// Package: shared types for the body-bias code controller.
// Assumes: nothing beyond standard SystemVerilog.
package abb_pkg;

    // Loop states: searching, timing met and held, stuck at a limit.
    typedef enum logic [1:0] {
        LOOP_RUN   = 2'd0,
        LOOP_LOCK  = 2'd1,
        LOOP_FAULT = 2'd2
    } loop_state_e;

endpackage

// File: rtl/abb_timing_detector.sv
// Module: two-flop timing detector.
// The first flop captures the replica path's result. The second flop resamples it,
// so a verdict never reflects a path that is still settling from a bias change.
// Assumes: path_ok is synchronous to clk.
module abb_timing_detector (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic path_ok,
    output logic pass_q
);
    logic cap_q;

    // Capture stage, then resample stage; both cleared by reset or re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cap_q  <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            cap_q  <= path_ok;
            pass_q <= cap_q;
        end
    end
endmodule

// File: rtl/abb_decision_pacer.sv
// Module: decision pacer.
// Counts WAIT_CYCLES idle clocks after each step or re-arm, then raises
// decide for one cycle while the loop is searching.
// Assumes: WAIT_CYCLES >= 2 so the detector pipeline has refilled.
module abb_decision_pacer #(
    parameter int WAIT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rearm,
    input  logic step,
    output logic decide
);
    localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(WAIT_CYCLES);

    logic [WAIT_W-1:0] wait_q;

    // Reload on reset, re-arm or step; otherwise count down while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || rearm || step) begin
            wait_q <= WAIT_LOAD;
        end else if (en && wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    // Verdict strobe once the settle window has run out.
    always_comb begin
        decide = en && !rearm && (wait_q == '0);
    end
endmodule

// File: rtl/abb_code_counter.sv
// Module: saturating bias code counter.
// Moves the code by one per step in the direction dir_up gives, and flags
// when the next move would leave the guard band.
// Assumes: CODE_MIN <= START_CODE <= CODE_MAX < 2**CODE_W.
module abb_code_counter #(
    parameter int CODE_W     = 6,
    parameter int CODE_MIN   = 4,
    parameter int CODE_MAX   = 60,
    parameter int START_CODE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              dir_up,
    output logic [CODE_W-1:0] code_q,
    output logic              at_limit
);
    localparam logic [CODE_W-1:0] MIN_C   = CODE_W'(CODE_MIN);
    localparam logic [CODE_W-1:0] MAX_C   = CODE_W'(CODE_MAX);
    localparam logic [CODE_W-1:0] START_C = CODE_W'(START_CODE);

    // The limit is checked in the direction currently selected.
    always_comb begin
        at_limit = dir_up ? (code_q >= MAX_C) : (code_q <= MIN_C);
    end

    // Load the start code on reset; take one guarded step per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= START_C;
        end else if (step && !at_limit) begin
            code_q <= dir_up ? code_q + 1'b1 : code_q - 1'b1;
        end
    end
endmodule

// File: rtl/abb_loop_fsm.sv
// Module: loop state machine.
// Turns verdicts into steps, a lock or a fault. Restart returns the loop to
// search from any state.
// Assumes: decide is only raised in LOOP_RUN.
module abb_loop_fsm
    import abb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        decide,
    input  logic        pass,
    input  logic        at_limit,
    output loop_state_e state_q,
    output logic        step
);
    // A step happens on a failing verdict that still has room to move.
    always_comb begin
        step = decide && !pass && !at_limit && !restart;
    end

    // State transitions on verdicts; restart and reset both re-arm the search.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state_q <= LOOP_RUN;
        end else begin
            case (state_q)
                LOOP_RUN: begin
                    if (decide && pass) begin
                        state_q <= LOOP_LOCK;
                    end else if (decide && at_limit) begin
                        state_q <= LOOP_FAULT;
                    end
                end
                LOOP_LOCK:  state_q <= LOOP_LOCK;
                LOOP_FAULT: state_q <= LOOP_FAULT;
                default:    state_q <= LOOP_RUN;
            endcase
        end
    end
endmodule

// File: rtl/abb_code_ctrl.sv
// Module: adaptive body bias code controller (top level).
// Wires the detector, pacer, counter and state machine together. The output
// code is chosen from the loop code or the external override.
// Assumes: the external converter follows bias_code within WAIT_CYCLES clocks.
module abb_code_ctrl
    import abb_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int CODE_MIN    = 4,
    parameter int CODE_MAX    = 60,
    parameter int START_CODE  = 32,
    parameter int WAIT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              path_ok,
    input  logic              dir_up,
    input  logic              restart,
    input  logic              ovr_sel,
    input  logic [CODE_W-1:0] ovr_code,
    output logic [CODE_W-1:0] bias_code,
    output logic              locked,
    output logic              limit_err
);
    loop_state_e       state_q;
    logic              pass_q;
    logic              decide;
    logic              step;
    logic              at_limit;
    logic [CODE_W-1:0] loop_code;
    logic              searching;

    // The loop searches only in the run state.
    always_comb begin
        searching = (state_q == LOOP_RUN);
    end

    abb_timing_detector det_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .path_ok (path_ok),
        .pass_q  (pass_q)
    );

    abb_decision_pacer #(.WAIT_CYCLES(WAIT_CYCLES)) pace_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (searching),
        .rearm  (restart),
        .step   (step),
        .decide (decide)
    );

    abb_code_counter #(
        .CODE_W     (CODE_W),
        .CODE_MIN   (CODE_MIN),
        .CODE_MAX   (CODE_MAX),
        .START_CODE (START_CODE)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .dir_up   (dir_up),
        .code_q   (loop_code),
        .at_limit (at_limit)
    );

    abb_loop_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .decide   (decide),
        .pass     (pass_q),
        .at_limit (at_limit),
        .state_q  (state_q),
        .step     (step)
    );

    // Output selection and status flags.
    always_comb begin
        bias_code = ovr_sel ? ovr_code : loop_code;
        locked    = (state_q == LOOP_LOCK);
        limit_err = (state_q == LOOP_FAULT);
    end
endmodule

// File: rtl/abb_code_ctrl_chk.sv
// Module: property checker for abb_code_ctrl, attached with bind.
// Assumes: it sees the top's internal loop code and strobes.
module abb_code_ctrl_chk #(
    parameter int CODE_W   = 6,
    parameter int CODE_MIN = 4,
    parameter int CODE_MAX = 60
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              decide,
    input logic [CODE_W-1:0] loop_code,
    input logic              locked,
    input logic              limit_err
);
    localparam logic [CODE_W-1:0] MIN_C = CODE_W'(CODE_MIN);
    localparam logic [CODE_W-1:0] MAX_C = CODE_W'(CODE_MAX);

    assert_code_in_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
        loop_code >= MIN_C && loop_code <= MAX_C);

    assert_lock_fault_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && limit_err));

    assert_fault_at_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        limit_err |-> (loop_code == MIN_C || loop_code == MAX_C));

    assert_lock_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        locked && !restart |=> locked && $stable(loop_code));

    assert_change_after_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(loop_code) |-> $past(decide));

    assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(loop_code) |->
            (loop_code - $past(loop_code) == CODE_W'(1)) ||
            ($past(loop_code) - loop_code == CODE_W'(1)));

    assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !locked && !limit_err);
endmodule

bind abb_code_ctrl abb_code_ctrl_chk #(
    .CODE_W   (CODE_W),
    .CODE_MIN (CODE_MIN),
    .CODE_MAX (CODE_MAX)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .decide    (decide),
    .loop_code (loop_code),
    .locked    (locked),
    .limit_err (limit_err)
);

// File: tb/abb_code_ctrl_tb_top.sv
// Bench for abb_code_ctrl. The replica path is modelled as passing once the
// code reaches a required value in the selected direction.
module abb_code_ctrl_tb_top;
    localparam int CW = 6;
    localparam int NV = 7;
    // Vector table: direction, required code, expected code, lock, fault.
    localparam int V_DIR  [NV] = '{1, 1, 1, 1, 0, 0, 0};
    localparam int V_NEED [NV] = '{40, 32, 20, 70, 10, -1, 45};
    localparam int V_CODE [NV] = '{40, 32, 32, 60, 10, 4, 32};
    localparam int V_LOCK [NV] = '{1, 1, 1, 0, 1, 0, 1};
    localparam int V_ERR  [NV] = '{0, 0, 0, 1, 0, 1, 0};

    logic clk = 1'b0;
    logic rst_n, dir_up, restart, ovr_sel, force_fail, path_ok;
    logic [CW-1:0] ovr_code, bias_code;
    logic locked, limit_err;
    int need;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Replica path model: faster as the code moves in the chosen direction.
    assign path_ok = force_fail ? 1'b0 :
                     (dir_up ? (int'(bias_code) >= need) : (int'(bias_code) <= need));

    abb_code_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .path_ok   (path_ok),
        .dir_up    (dir_up),
        .restart   (restart),
        .ovr_sel   (ovr_sel),
        .ovr_code  (ovr_code),
        .bias_code (bias_code),
        .locked    (locked),
        .limit_err (limit_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; restart = 1'b0; ovr_sel = 1'b0; force_fail = 1'b0;
        ovr_code = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !(locked || limit_err); i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        logic [CW-1:0] c0;
        dir_up = 1'b1; need = 40;
        // R1: reset state
        do_reset();
        check(bias_code == 6'd32, "R1 code", bias_code, 32);
        check(locked == 1'b0, "R1 locked", locked, 0);
        check(limit_err == 1'b0, "R1 limit_err", limit_err, 0);

        // Table walk: R3 direction, R4 lock, R5 saturation
        for (int v = 0; v < NV; v++) begin
            dir_up = V_DIR[v][0]; need = V_NEED[v];
            do_reset();
            wait_done();
            check(int'(bias_code) == V_CODE[v], "R3/R4/R5 code", bias_code, V_CODE[v]);
            check(int'(locked) == V_LOCK[v], "R4 locked", locked, V_LOCK[v]);
            check(int'(limit_err) == V_ERR[v], "R5 limit_err", limit_err, V_ERR[v]);
        end

        // R2 pacing and R3 unit step
        dir_up = 1'b1; need = 40;
        do_reset();
        c0 = bias_code; n = 0;
        while (bias_code == c0 && n < 100) begin @(negedge clk); n++; end
        check(bias_code == 6'd33, "R3 first step", bias_code, 33);
        c0 = bias_code; n = 0;
        while (bias_code == c0 && n < 100) begin @(negedge clk); n++; end
        check(n == 5, "R2 verdict spacing", n, 5);
        check(bias_code == 6'd34, "R3 second step", bias_code, 34);

        // R4: path result ignored after lock
        wait_done();
        force_fail = 1'b1;
        repeat (30) @(negedge clk);
        check(bias_code == 6'd40, "R4 held code", bias_code, 40);
        check(locked == 1'b1, "R4 held lock", locked, 1);
        force_fail = 1'b0;

        // R7: override and return
        ovr_sel = 1'b1; ovr_code = 6'd7;
        #1;
        check(bias_code == 6'd7, "R7 override", bias_code, 7);
        @(negedge clk);
        ovr_sel = 1'b0;
        #1;
        check(bias_code == 6'd40, "R7 loop code back", bias_code, 40);

        // R6: fault at upper limit, then re-arm downward
        dir_up = 1'b1; need = 70;
        do_reset();
        wait_done();
        check(limit_err == 1'b1, "R5 fault raised", limit_err, 1);
        dir_up = 1'b0; need = 50;
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        check(limit_err == 1'b0, "R6 fault cleared", limit_err, 0);
        check(bias_code == 6'd60, "R6 code kept", bias_code, 60);
        wait_done();
        check(bias_code == 6'd50, "R6 relock code", bias_code, 50);
        check(locked == 1'b1, "R6 relocked", locked, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule